// File: doc/BRIEF.md
# Descriptor Ring Pointer Controller

This block holds the control and status registers of a bus master that works through a ring of descriptors in memory. Software programs the ring's base address, the number of entries (written as count minus one) and a producer index. It then sets a run bit. The controller walks the ring from its own consumer index up to the producer index. It offers one entry at a time to a transaction sequencer, and the sequencer fetches the descriptor, runs the bus transfer and reports the outcome.

The request to the sequencer carries the entry index and that entry's byte address. The sequencer answers with a single-cycle done pulse. The pulse carries a success flag and two control bits copied from the descriptor: "raise an interrupt" and "halt on failure". From these the controller moves the consumer index forward, updates two sticky interrupt flags that software clears by writing ones, and drives a single interrupt line. A two-bit bus-speed selection is also held here for the physical layer.

Top module: `ring_ctl`

## Requirements
- R1: After reset every register reads zero, `seq_req` is 0, `irq` is 0 and `bus_speed` is 0.
- R2: Register readback works as follows. The base address sits at offsets 0x100 (bits 31:0) and 0x104 (bits 63:32). The control register at 0x108 holds run in bit 0, error-interrupt enable in bit 4 and the producer index in bits 23:16. The ring size at 0x110 holds bits 7:0. The retry word at 0x114 keeps all 32 bits. The timing register at 0x300 keeps only bits 31:30, and its other bits read 0.
- R3: While run is 1, no request is outstanding and the consumer index differs from the producer index, the controller raises `seq_req`. `seq_idx` equals the consumer index and `seq_addr` equals base + 16 × index. The request is held, and stays unchanged, until `seq_done`. Status bit 0 (in progress) equals `seq_req`.
- R4: The consumer index can be read in status bits 23:16 and changes only on a done. On a successful done it advances by one, wrapping from the ring-size value to 0. Issuing stops once it equals the producer index.
- R5: Status bit 5 (completion flag) is set by a done whose `seq_irq_req` is 1, whether or not the transfer succeeded. A done with `seq_irq_req` 0 leaves it unchanged.
- R6: Status bit 4 (error flag) is set by a done with `seq_ok` 0 only while control bit 4 is 1.
- R7: A done with `seq_ok` 0 and `seq_soe` 1 clears the run bit and leaves the consumer index unchanged. With `seq_soe` 0, a failed entry advances the index just as a successful one does.
- R8: Writing 1 to status bit 4 or bit 5 clears that flag, and writing 0 leaves it unchanged. If a done event sets a flag in the same cycle as a write clears it, the flag ends up set.
- R9: `irq` is 1 exactly when the completion flag is 1, or when the error flag and control bit 4 are both 1.
- R10: `bus_speed` equals timing register bits 31:30. The encoding is 0 = 80 kHz, 1 = 100 kHz, 2 = 400 kHz and 3 = 1 MHz.
- R11: Writes to the status register's index field (bits 23:16) and to its bit 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| seq_req | output | 1 | Entry offered to the sequencer |
| seq_idx | output | 8 | Index of the offered entry |
| seq_addr | output | 64 | Byte address of the offered entry |
| seq_done | input | 1 | Sequencer finished the offered entry |
| seq_ok | input | 1 | Transfer succeeded |
| seq_irq_req | input | 1 | Descriptor asked for a completion interrupt |
| seq_soe | input | 1 | Descriptor asked to halt on failure |
| irq | output | 1 | Interrupt line |
| bus_speed | output | 2 | Bus speed selection |

## Verification
A software write that clears the completion flag can land in the same cycle as a sequencer done that sets it again. The bench provokes this by timing a status write of bit 5 to the exact cycle in which its sequencer model pulses done, with `seq_irq_req` set. The flag must read back as 1 afterwards, and the index must still advance. The same kind of overlap arises between the halt-on-failure clearing of the run bit and issue of the next entry; the bench checks that case by confirming that no request appears for the entry after the failing one.

// File: rtl/ring_ctl.sv
module ring_ctl #(
  parameter int AW = 12,
  parameter int PW = 8,
  parameter int DESC_BYTES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          seq_req,
  output logic [PW-1:0] seq_idx,
  output logic [63:0]   seq_addr,
  input  logic          seq_done,
  input  logic          seq_ok,
  input  logic          seq_irq_req,
  input  logic          seq_soe,
  output logic          irq,
  output logic [1:0]    bus_speed
);
  localparam logic [AW-1:0] OFF_BLO = AW'(12'h100);
  localparam logic [AW-1:0] OFF_BHI = AW'(12'h104);
  localparam logic [AW-1:0] OFF_CTL = AW'(12'h108);
  localparam logic [AW-1:0] OFF_STS = AW'(12'h10C);
  localparam logic [AW-1:0] OFF_SIZ = AW'(12'h110);
  localparam logic [AW-1:0] OFF_RTY = AW'(12'h114);
  localparam logic [AW-1:0] OFF_TIM = AW'(12'h300);

  logic [63:0]   base;
  logic          run, eie, req, done_f, err_f;
  logic [PW-1:0] head, tail, size_m1;
  logic [31:0]   retry;
  logic [1:0]    spd;

  wire fin  = req & seq_done;
  wire fail = fin & ~seq_ok;
  wire halt = fail & seq_soe;
  wire [PW-1:0] tail_nx = (tail == size_m1) ? '0 : tail + 1'b1;
  wire wr_sts = reg_we && reg_addr == OFF_STS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0; run <= 1'b0; eie <= 1'b0; head <= '0; tail <= '0;
      size_m1 <= '0; retry <= '0; spd <= '0; req <= 1'b0;
      done_f <= 1'b0; err_f <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          OFF_BLO: base[31:0]  <= reg_wdata;
          OFF_BHI: base[63:32] <= reg_wdata;
          OFF_CTL: begin
            run  <= reg_wdata[0];
            eie  <= reg_wdata[4];
            head <= reg_wdata[16 +: PW];
          end
          OFF_SIZ: size_m1 <= reg_wdata[PW-1:0];
          OFF_RTY: retry   <= reg_wdata;
          OFF_TIM: spd     <= reg_wdata[31:30];
          default: ;
        endcase
      end
      if (halt) run <= 1'b0;
      if (wr_sts && reg_wdata[4]) err_f <= 1'b0;
      if (wr_sts && reg_wdata[5]) done_f <= 1'b0;
      if (fin && seq_irq_req) done_f <= 1'b1;
      if (fail && eie) err_f <= 1'b1;
      if (fin) begin
        req <= 1'b0;
        if (!halt) tail <= tail_nx;
      end else if (!req && run && tail != head) begin
        req <= 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_BLO: reg_rdata = base[31:0];
      OFF_BHI: reg_rdata = base[63:32];
      OFF_CTL: begin
        reg_rdata[0] = run;
        reg_rdata[4] = eie;
        reg_rdata[16 +: PW] = head;
      end
      OFF_STS: begin
        reg_rdata[0] = req;
        reg_rdata[4] = err_f;
        reg_rdata[5] = done_f;
        reg_rdata[16 +: PW] = tail;
      end
      OFF_SIZ: reg_rdata[PW-1:0] = size_m1;
      OFF_RTY: reg_rdata = retry;
      OFF_TIM: reg_rdata[31:30] = spd;
      default: ;
    endcase
  end

  assign seq_req   = req;
  assign seq_idx   = tail;
  assign seq_addr  = base + 64'(tail) * 64'(DESC_BYTES);
  assign irq       = done_f | (err_f & eie);
  assign bus_speed = spd;
endmodule

module ring_ctl_chk #(parameter int PW = 8) (
  input logic          clk,
  input logic          rst_n,
  input logic          seq_req,
  input logic          seq_done,
  input logic          seq_ok,
  input logic          seq_irq_req,
  input logic          seq_soe,
  input logic [PW-1:0] seq_idx,
  input logic [PW-1:0] tail,
  input logic          run,
  input logic          eie,
  input logic          done_f,
  input logic          err_f
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    seq_req && !seq_done |=> seq_req); // R3
  AST_IDX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_req && !seq_done |=> $stable(seq_idx)); // R3
  AST_TAIL_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_req && seq_done) |=> $stable(tail)); // R4
  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    seq_req && seq_done && seq_irq_req |=> done_f); // R5
  AST_MASKED_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    seq_req && seq_done && !seq_ok && !eie && !err_f |=> !err_f); // R6
  AST_HALT_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    seq_req && seq_done && !seq_ok && seq_soe |=> !run && $stable(tail)); // R7
endmodule

bind ring_ctl ring_ctl_chk #(.PW(PW)) i_ring_ctl_chk (
  .clk(clk), .rst_n(rst_n), .seq_req(seq_req), .seq_done(seq_done),
  .seq_ok(seq_ok), .seq_irq_req(seq_irq_req), .seq_soe(seq_soe),
  .seq_idx(seq_idx), .tail(tail), .run(run), .eie(eie),
  .done_f(done_f), .err_f(err_f)
);

// File: tb/test_ring_ctl.sv
module test_ring_ctl;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] BASE = 64'h0000_0002_1000_0000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        seq_req, seq_done = 1'b0, seq_ok = 1'b0, seq_irq_req = 1'b0, seq_soe = 1'b0;
  logic [7:0]  seq_idx;
  logic [63:0] seq_addr;
  logic        irq;
  logic [1:0]  bus_speed;

  int checks = 0, errors = 0;
  int exp_q[$];
  bit r_ok[4], r_irq[4], r_soe[4];
  bit finished = 1'b0;
  logic [31:0] rv;

  ring_ctl i_ring_ctl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic expect_entries(int first, int n);
    for (int k = 0; k < n; k++) exp_q.push_back((first + k) % 4);
  endtask

  // monitor: sequencer model, pops expected entry indices
  always begin
    @(negedge clk);
    if (seq_req) begin
      if (exp_q.size() == 0) begin
        chk("R3 unexpected request idx", 64'(seq_idx), 64'hFFFF);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk("R3 seq_idx", 64'(seq_idx), 64'(e));
        chk("R3 seq_addr", seq_addr, BASE + 64'(e) * 64'd16);
      end
      repeat (2) @(negedge clk);
      seq_done = 1'b1;
      seq_ok = r_ok[seq_idx[1:0]];
      seq_irq_req = r_irq[seq_idx[1:0]];
      seq_soe = r_soe[seq_idx[1:0]];
      @(negedge clk);
      seq_done = 1'b0;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin r_ok[i] = 1; r_irq[i] = 0; r_soe[i] = 0; end
    r_irq[1] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(12'h10C, rv); chk("R1 status", 64'(rv), 0);
    rd(12'h108, rv); chk("R1 ctrl", 64'(rv), 0);
    chk("R1 irq/req/speed", {61'b0, irq, seq_req, bus_speed != 0}, 0);

    wr(12'h100, BASE[31:0]); wr(12'h104, BASE[63:32]);
    wr(12'h110, 32'h3); wr(12'h114, 32'h0000_005A);
    wr(12'h300, 32'hBFFF_FFFF);
    rd(12'h100, rv); chk("R2 base lo", 64'(rv), 64'(BASE[31:0]));
    rd(12'h104, rv); chk("R2 base hi", 64'(rv), 64'(BASE[63:32]));
    rd(12'h110, rv); chk("R2 size", 64'(rv), 3);
    rd(12'h114, rv); chk("R2 retry", 64'(rv), 64'h5A);
    rd(12'h300, rv); chk("R2 timing", 64'(rv), 64'h8000_0000);
    chk("R10 bus_speed", 64'(bus_speed), 2);

    expect_entries(0, 3);
    wr(12'h108, 32'h0003_0011);
    rd(12'h108, rv); chk("R2 ctrl", 64'(rv), 64'h0003_0011);
    repeat (30) @(negedge clk);
    chk("R4 queue drained", 64'(exp_q.size()), 0);
    rd(12'h10C, rv); chk("R4 R5 status after 3", 64'(rv), 64'h0003_0020);
    chk("R9 irq from completion", 64'(irq), 1);

    wr(12'h10C, 32'h0);
    rd(12'h10C, rv); chk("R8 write zero keeps flag", 64'(rv), 64'h0003_0020);
    wr(12'h10C, 32'h20);
    rd(12'h10C, rv); chk("R8 clear completion", 64'(rv), 64'h0003_0000);
    chk("R9 irq low", 64'(irq), 0);

    r_irq[1] = 0;
    expect_entries(3, 2);
    wr(12'h108, 32'h0001_0011);
    repeat (30) @(negedge clk);
    rd(12'h10C, rv); chk("R4 wrap tail", 64'(rv), 64'h0001_0000);

    r_ok[1] = 0;
    expect_entries(1, 1);
    wr(12'h108, 32'h0002_0001);
    repeat (20) @(negedge clk);
    rd(12'h10C, rv); chk("R6 R7 masked failure advances", 64'(rv), 64'h0002_0000);
    chk("R9 irq masked", 64'(irq), 0);

    r_ok[2] = 0; r_soe[2] = 1;
    expect_entries(2, 1);
    wr(12'h108, 32'h0000_0011);
    repeat (30) @(negedge clk);
    chk("R7 no further request", 64'(exp_q.size()), 0);
    rd(12'h10C, rv); chk("R6 R7 halted status", 64'(rv), 64'h0002_0010);
    rd(12'h108, rv); chk("R7 run cleared", 64'(rv), 64'h0000_0010);
    chk("R9 irq from error", 64'(irq), 1);

    wr(12'h10C, 32'h00FF_0011);
    rd(12'h10C, rv); chk("R11 R8 index read-only", 64'(rv), 64'h0002_0000);
    chk("R9 irq after clear", 64'(irq), 0);

    r_ok[2] = 1; r_soe[2] = 0; r_irq[2] = 1;
    expect_entries(2, 1);
    wr(12'h108, 32'h0003_0011);
    while (!seq_req) @(negedge clk);
    repeat (2) @(negedge clk);
    wr(12'h10C, 32'h20);
    repeat (5) @(negedge clk);
    rd(12'h10C, rv); chk("R8 set wins over clear", 64'(rv), 64'h0003_0020);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule